// File: doc/BRIEF.md
# Broadcast Invalidation Completion Tracker

This block sits inside a memory cache controller and handles the invalidation of every sharer of a cache line. On each trigger (a line being evicted, or a write landing on a line that other caches hold), it compares the directory's copy count with a threshold fixed at build time. A count at or below the threshold is handed to a targeted-invalidation path through a one-cycle hand-off pulse. A count above the threshold starts a broadcast.

For a broadcast, the block drives one command flit. The flit carries the write opcode and the fixed all-caches address 0x3, and the line index is split across the data word and the two low byte-enable bits. The block then accepts responses. Only caches that still hold a copy answer, and a cache that holds the line in both its instruction and data arrays answers twice. So the block counts individual responses, not caches, against the copy count it loaded at the trigger. When the count is reached, it raises `done` for one cycle. If the trigger was a write, it also raises `wr_ack_release` so that the write acknowledgement, held back until then, can go out.

The controller has four named states. IDLE waits for a trigger. ISSUE presents the broadcast flit. COLLECT counts responses. FINISH is the single completion cycle. The named transitions are:
- IDLE→IDLE on a targeted hand-off.
- IDLE→ISSUE on a broadcast trigger.
- ISSUE→COLLECT when the flit is accepted.
- COLLECT→FINISH on the response that reaches the count.
- FINISH→IDLE unconditionally.

Only one broadcast is in flight at a time. Further triggers are back-pressured until the block returns to IDLE.

Top module: `bcast_inval_tracker`

## Requirements
- R1: After reset the block is idle: `trig_ready`=1, and `cmd_valid`, `rsp_ready`, `done`, `wr_ack_release` and `tgt_valid` are all 0.
- R2: A trigger accepted with `trig_copies` <= `THRESH` issues no command. In the following cycle it produces a one-cycle `tgt_valid` carrying the trigger's line and write flag, and `trig_ready` stays 1.
- R3: A trigger accepted with `trig_copies` > `THRESH` raises `cmd_valid` in the following cycle. The flit stays valid and unchanged until the cycle in which `cmd_ready` is 1, and `cmd_valid` is 0 in the cycle after that.
- R4: The flit has the following fields:
  - `cmd_opcode` = 2'b10 (write).
  - `cmd_addr` = 3.
  - `cmd_eop` = 1.
  - `cmd_wdata` = line index bits [DATA_W-1:0].
  - `cmd_be[1:0]` = line index bits [DATA_W+1:DATA_W], with the remaining byte-enable bits 0.
- R5: `rsp_ready` is 1 only from the cycle after the flit is accepted until the final response is taken. Responses offered at any other time are not counted.
- R6: `done` is a one-cycle pulse in the cycle after the response that brings the accepted-response count to the loaded copy count. It is never raised earlier.
- R7: `wr_ack_release` pulses together with `done` when the broadcast was started by a write trigger (`trig_is_write`=1), and stays 0 otherwise.
- R8: From accepting a broadcast trigger until the cycle after `done`, `trig_ready` is 0 and no trigger is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Invalidation trigger present |
| trig_ready | output | 1 | Trigger accepted this cycle if valid |
| trig_is_write | input | 1 | 1 = write to shared line, 0 = line replacement |
| trig_line | input | LINE_W | Line index to invalidate |
| trig_copies | input | CNT_W | Directory copy count (expected responses) |
| tgt_valid | output | 1 | One-cycle hand-off to targeted invalidation |
| tgt_line | output | LINE_W | Line index for the hand-off |
| tgt_is_write | output | 1 | Write flag for the hand-off |
| cmd_valid | output | 1 | Broadcast flit valid |
| cmd_ready | input | 1 | Network accepts flit |
| cmd_opcode | output | 2 | Command code (write) |
| cmd_addr | output | ADDR_W | Broadcast address |
| cmd_wdata | output | DATA_W | Low part of line index |
| cmd_be | output | BE_W | Byte enables, high line-index bits in [1:0] |
| cmd_eop | output | 1 | End of packet |
| rsp_valid | input | 1 | One invalidation response present |
| rsp_ready | output | 1 | Response accepted this cycle if valid |
| done | output | 1 | Broadcast invalidation complete |
| wr_ack_release | output | 1 | Pending write acknowledgement may be sent |

## Verification
The bench uses these parameters: `DATA_W`=16, `BE_W`=4, `THRESH`=3 and `CNT_W`=4. With this line width, the top two line-index bits move into the byte enables, and a line with both set makes that split visible. The small threshold puts the decision boundary at copy counts 3 and 4 within a short run. The four-bit counter lets a broadcast wait for its full range of 15 responses, so the counter's top value is reached.

// File: rtl/bct_pkg.sv
package bct_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_COLLECT,
        ST_FINISH
    } bct_state_e;

    localparam logic [1:0] OP_WRITE = 2'b10;
    localparam int unsigned BCAST_ADDR_VAL = 3;

endpackage

// File: rtl/bct_decide.sv
// Route selection: broadcast when the sharer count exceeds the threshold.
module bct_decide #(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned THRESH = 4
) (
    input  logic [CNT_W-1:0] copies,
    output logic             use_bcast
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

    always_comb begin
        use_bcast = (copies > LIMIT);
    end
endmodule

// File: rtl/bct_pack.sv
// Splits a line index across the data word and the two low byte enables.
module bct_pack #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BE_W   = 4
) (
    input  logic [DATA_W+1:0] line,
    output logic [DATA_W-1:0] wdata,
    output logic [BE_W-1:0]   be
);
    localparam int unsigned PAD_W = BE_W - 2;

    assign wdata = line[DATA_W-1:0];

    generate
        if (BE_W > 2) begin : g_pad
            assign be = {{PAD_W{1'b0}}, line[DATA_W+1:DATA_W]};
        end else begin : g_exact
            assign be = line[DATA_W+1:DATA_W];
        end
    endgenerate
endmodule

// File: rtl/bct_resp_counter.sv
// Counts accepted responses against a loaded expectation.
module bct_resp_counter #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] exp_in,
    input  logic             armed,
    input  logic             inc,
    output logic             last
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] exp_q;
    logic [CNT_W-1:0] cnt_next;

    assign cnt_next = cnt_q + CNT_W'(1);
    assign last     = armed && inc && (cnt_next == exp_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= '0;
        end else if (load) begin
            cnt_q <= '0;
            exp_q <= exp_in;
        end else if (armed && inc) begin
            cnt_q <= cnt_next;
        end
    end

    // While collecting, the count never reaches or passes the expectation.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (cnt_q < exp_q));
endmodule

// File: rtl/bcast_inval_tracker.sv
module bcast_inval_tracker
    import bct_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BE_W   = 4,
    parameter int unsigned ADDR_W = 40,
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned THRESH = 4,
    localparam int unsigned LINE_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    output logic              trig_ready,
    input  logic              trig_is_write,
    input  logic [LINE_W-1:0] trig_line,
    input  logic [CNT_W-1:0]  trig_copies,
    output logic              tgt_valid,
    output logic [LINE_W-1:0] tgt_line,
    output logic              tgt_is_write,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_opcode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    output logic [BE_W-1:0]   cmd_be,
    output logic              cmd_eop,
    input  logic              rsp_valid,
    output logic              rsp_ready,
    output logic              done,
    output logic              wr_ack_release
);
    localparam logic [ADDR_W-1:0] BCAST_ADDR = ADDR_W'(BCAST_ADDR_VAL);

    bct_state_e        state_q, state_d;
    logic [LINE_W-1:0] line_q;
    logic              write_q;
    logic              tgt_q;
    logic              use_bcast;
    logic              accept;
    logic              cmd_fire;
    logic              last_rsp;
    logic [DATA_W-1:0] packed_wdata;
    logic [BE_W-1:0]   packed_be;

    assign accept   = trig_valid && trig_ready;
    assign cmd_fire = cmd_valid && cmd_ready;

    bct_decide #(.CNT_W(CNT_W), .THRESH(THRESH)) decide_i (
        .copies    (trig_copies),
        .use_bcast (use_bcast)
    );

    bct_pack #(.DATA_W(DATA_W), .BE_W(BE_W)) pack_i (
        .line  (line_q),
        .wdata (packed_wdata),
        .be    (packed_be)
    );

    bct_resp_counter #(.CNT_W(CNT_W)) count_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept && use_bcast),
        .exp_in (trig_copies),
        .armed  (state_q == ST_COLLECT),
        .inc    (rsp_valid),
        .last   (last_rsp)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept && use_bcast) state_d = ST_ISSUE;
            ST_ISSUE:   if (cmd_fire)            state_d = ST_COLLECT;
            ST_COLLECT: if (last_rsp)            state_d = ST_FINISH;
            ST_FINISH:                           state_d = ST_IDLE;
            default:                             state_d = ST_IDLE;
        endcase
    end

    // State register and captured trigger
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            line_q  <= '0;
            write_q <= 1'b0;
            tgt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            tgt_q   <= accept && !use_bcast;
            if (accept) begin
                line_q  <= trig_line;
                write_q <= trig_is_write;
            end
        end
    end

    // Outputs
    always_comb begin
        trig_ready     = 1'b0;
        cmd_valid      = 1'b0;
        rsp_ready      = 1'b0;
        done           = 1'b0;
        wr_ack_release = 1'b0;
        unique case (state_q)
            ST_IDLE:    trig_ready = 1'b1;
            ST_ISSUE:   cmd_valid  = 1'b1;
            ST_COLLECT: rsp_ready  = 1'b1;
            ST_FINISH: begin
                done           = 1'b1;
                wr_ack_release = write_q;
            end
            default: ;
        endcase
    end

    assign tgt_valid    = tgt_q;
    assign tgt_line     = line_q;
    assign tgt_is_write = write_q;
    assign cmd_opcode   = OP_WRITE;
    assign cmd_addr     = BCAST_ADDR;
    assign cmd_wdata    = packed_wdata;
    assign cmd_be       = packed_be;
    assign cmd_eop      = 1'b1;

    // R3: an unaccepted flit stays valid with the same contents
    assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_wdata) && $stable(cmd_be)));

    // R5: responses are never taken while the command is pending
    assert_rsp_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_ready && cmd_valid));

    // R6: completion lasts exactly one cycle
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: write release only accompanies completion
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack_release |-> done);

    // R8: no trigger is taken once a broadcast is started
    assert_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> !trig_ready);

    // R2: a targeted hand-off never coincides with a broadcast flit
    assert_tgt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_valid |-> !cmd_valid);
endmodule

// File: tb/bcast_inval_tracker_tb_top.sv
module bcast_inval_tracker_tb_top;
    localparam int unsigned DATA_W = 16;
    localparam int unsigned BE_W   = 4;
    localparam int unsigned ADDR_W = 24;
    localparam int unsigned CNT_W  = 4;
    localparam int unsigned THRESH = 3;
    localparam int unsigned LINE_W = DATA_W + 2;
    localparam int unsigned NVEC   = 8;

    // Vector: {is_write, line[17:0], copies[3:0], gap[1:0]}
    localparam logic [24:0] VECS [NVEC] = '{
        {1'b1, 18'h00123, 4'd3,  2'd0},
        {1'b0, 18'h1A5C3, 4'd4,  2'd0},
        {1'b1, 18'h2BEEF, 4'd5,  2'd1},
        {1'b0, 18'h00077, 4'd0,  2'd0},
        {1'b1, 18'h3FFFF, 4'd15, 2'd0},
        {1'b0, 18'h10F0F, 4'd7,  2'd2},
        {1'b1, 18'h24444, 4'd2,  2'd0},
        {1'b1, 18'h30001, 4'd4,  2'd3}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trig_valid = 1'b0;
    logic              trig_ready;
    logic              trig_is_write = 1'b0;
    logic [LINE_W-1:0] trig_line = '0;
    logic [CNT_W-1:0]  trig_copies = '0;
    logic              tgt_valid;
    logic [LINE_W-1:0] tgt_line;
    logic              tgt_is_write;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [1:0]        cmd_opcode;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [BE_W-1:0]   cmd_be;
    logic              cmd_eop;
    logic              rsp_valid = 1'b0;
    logic              rsp_ready;
    logic              done;
    logic              wr_ack_release;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    bcast_inval_tracker #(
        .DATA_W(DATA_W), .BE_W(BE_W), .ADDR_W(ADDR_W),
        .CNT_W(CNT_W), .THRESH(THRESH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(trig_valid), .trig_ready(trig_ready),
        .trig_is_write(trig_is_write), .trig_line(trig_line), .trig_copies(trig_copies),
        .tgt_valid(tgt_valid), .tgt_line(tgt_line), .tgt_is_write(tgt_is_write),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_be(cmd_be), .cmd_eop(cmd_eop),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .done(done), .wr_ack_release(wr_ack_release)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic run_vec(input logic [24:0] v);
        logic              wr;
        logic [LINE_W-1:0] line;
        int                copies;
        int                gap;
        wr     = v[24];
        line   = v[23:6];
        copies = int'(v[5:2]);
        gap    = int'(v[1:0]);

        @(negedge clk);
        chk("R8 ready before trigger", trig_ready, 1);
        trig_valid    = 1'b1;
        trig_is_write = wr;
        trig_line     = line;
        trig_copies   = CNT_W'(copies);
        @(negedge clk);
        trig_valid = 1'b0;
        if (copies <= THRESH) begin
            chk("R2 tgt_valid", tgt_valid, 1);
            chk("R2 tgt_line", tgt_line, line);
            chk("R2 tgt_is_write", tgt_is_write, wr);
            chk("R2 no command", cmd_valid, 0);
            @(negedge clk);
            chk("R2 tgt pulse ends", tgt_valid, 0);
            chk("R2 ready kept", trig_ready, 1);
        end else begin
            chk("R3 cmd_valid", cmd_valid, 1);
            chk("R4 opcode", cmd_opcode, 2'b10);
            chk("R4 addr", cmd_addr, 3);
            chk("R4 eop", cmd_eop, 1);
            chk("R4 wdata", cmd_wdata, line[DATA_W-1:0]);
            chk("R4 be", cmd_be, {2'b00, line[LINE_W-1:DATA_W]});
            chk("R8 busy", trig_ready, 0);
            chk("R5 not ready during issue", rsp_ready, 0);
            rsp_valid = 1'b1;   // stray response, must not count (R5)
            for (int k = 0; k < gap; k++) begin
                @(negedge clk);
                chk("R3 hold valid", cmd_valid, 1);
                chk("R3 hold wdata", cmd_wdata, line[DATA_W-1:0]);
            end
            rsp_valid = 1'b0;
            cmd_ready = 1'b1;
            @(negedge clk);
            cmd_ready = 1'b0;
            chk("R3 drop after accept", cmd_valid, 0);
            chk("R5 ready in collect", rsp_ready, 1);
            trig_valid    = 1'b1;
            trig_copies   = CNT_W'(1);
            @(negedge clk);
            chk("R8 trigger held off", trig_ready, 0);
            trig_valid = 1'b0;
            for (int i = 0; i < copies; i++) begin
                rsp_valid = 1'b1;
                @(negedge clk);
                rsp_valid = 1'b0;
                if (i < copies - 1) begin
                    chk("R6 no early done", done, 0);
                    chk("R8 no hand-off while busy", tgt_valid, 0);
                    for (int k = 0; k < gap; k++) @(negedge clk);
                end
            end
            chk("R6 done", done, 1);
            chk("R7 release", wr_ack_release, wr);
            chk("R5 ready off after last", rsp_ready, 0);
            @(negedge clk);
            chk("R6 done one cycle", done, 0);
            chk("R8 ready after done", trig_ready, 1);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 trig_ready", trig_ready, 1);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 rsp_ready", rsp_ready, 0);
        chk("R1 done", done, 0);
        chk("R1 wr_ack_release", wr_ack_release, 0);
        chk("R1 tgt_valid", tgt_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int n = 0; n < NVEC; n++) run_vec(VECS[n]);

        // Stray responses while idle are not counted (R5)
        rsp_valid = 1'b1;
        @(negedge clk);
        chk("R5 idle not ready", rsp_ready, 0);
        @(negedge clk);
        chk("R6 no done from stray", done, 0);
        rsp_valid = 1'b0;
        run_vec({1'b0, 18'h0ABCD, 4'd4, 2'd0});

        // Reset in the middle of a collection returns to idle (R1)
        @(negedge clk);
        trig_valid = 1'b1; trig_copies = CNT_W'(9); trig_line = 18'h01111;
        @(negedge clk);
        trig_valid = 1'b0; cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 idle after reset", trig_ready, 1);
        chk("R1 no rsp_ready after reset", rsp_ready, 0);
        run_vec({1'b1, 18'h22222, 4'd6, 2'd1});

        finished = 1'b1;
        summary();
    end
endmodule